// File: doc/BRIEF.md
# Command Address Replay Buffer

This block holds a small per-channel store of DRAM command words and plays a
chosen slice of them onto the command/address pins. Software first sets a load
index, then writes 64-bit command words one after another; each word lands at
the current index and the index steps forward by itself. An optional per-rank
mirroring stage rewrites the address and bank bits of a word as it is stored,
so that ranks wired with swapped pin pairs receive the intended values.

Once the channel is in replay mode, a control write with the go bit set replays
every word from a first slot to a last slot inclusive. Between two issued words
the bus carries a programmable number of idle cycles. When the last word has
gone out, the block raises a done flag and leaves its current-slot indication on
the last slot. Misuse, such as a reversed slot range or a store write during a
replay, raises a sticky error flag that a later control write can clear.

Top module: `cab_replay`

## Requirements
- R1: An issued word drives the pins from its own fields: address from bits 15:0, bank from bits 26:24, active-low chip selects from bits 35:32, command code from bits 42:40, ODT from bits 51:48 and CKE from bits 59:56. The first word of a replay is on the pins in the cycle after the accepted go write.
- R2: A pointer write sets the load index; each accepted word write stores at the load index and then advances it by one, slot 7 wrapping to slot 0.
- R3: A go write is accepted only when the mode input is 2 (replay); mode values 0 (idle), 1 (test) and 3 (normal) make it a no-op with no word issued and the done flag unchanged. An accepted replay issues slots first to last inclusive, in ascending order.
- R4: Consecutive issued words are separated by exactly G idle cycles, where G is the gap field, and a gap field of 0 means G = 3.
- R5: An idle cycle drives command code 7 (NOP; the other codes are MRS 0, REF 1, PRE 2, ACT 3, WR 4, RD 5, ZQ 6), chip selects 4'b1111, address 0, bank 0, ODT 0 and CKE 4'b1111; the pins are idle after reset and in the cycle after the last word.
- R6: In the cycle after the last word, the done flag is 1 and the current slot equals the last slot; an accepted go write clears the done flag.
- R7: An accepted go write whose last slot is below its first slot sets the error flag and issues nothing.
- R8: A word write while a replay runs is ignored (store contents and load index unchanged) and sets the error flag.
- R9: A control write with the clear bit set clears the error flag, unless the same write raises a new error.
- R10: When mirroring is enabled for any rank whose chip select is low in a word, the stored word has address bits 3/4, 5/6, 7/8 and bank bits 0/1 swapped; the mirror setting applies at load time only.
- R11: After reset the done flag, error flag and current slot are 0 and the load index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Channel mode; 2 enables replay |
| mirror_en | input | 4 | Per-rank mirroring enable for loads |
| ptr_wr | input | 1 | Load-index write strobe |
| ptr_val | input | 3 | New load index |
| ent_wr | input | 1 | Word write strobe |
| ent_data | input | 64 | Command word to store |
| ctl_wr | input | 1 | Control write strobe |
| ctl_gap | input | 3 | Idle cycles between words (0 means 3) |
| ctl_start | input | 3 | First slot of the replay |
| ctl_end | input | 3 | Last slot of the replay |
| ctl_go | input | 1 | Launch a replay with this control write |
| ctl_clr_err | input | 1 | Clear the error flag with this control write |
| ca_addr | output | 16 | Address pins |
| ca_bank | output | 3 | Bank pins |
| ca_cs_n | output | 4 | Chip selects, active low |
| ca_cmd | output | 3 | Command code |
| ca_odt | output | 4 | ODT pins |
| ca_cke | output | 4 | CKE pins |
| cur_ptr | output | 3 | Slot most recently issued |
| test_done | output | 1 | Replay completed |
| err | output | 1 | Sticky error flag |

## Verification
The assertions take the strobes to be single-cycle pulses and the control fields to be stable only while their strobe is high, and they treat a bus cycle with code 7 and all chip selects high as idle. The bench therefore loads only words with at least one chip select low, so every replayed word is visible to the monitor, and it raises each strobe for exactly one clock edge. The gap check counts idle cycles between words issued inside one replay, so the bench never starts a new replay until the done flag of the previous one has been seen.

// File: rtl/cab_pkg.sv
package cab_pkg;

  localparam int WORD_W   = 64;
  localparam int RANKS    = 4;

  // field positions inside a stored word
  localparam int ADDR_LSB = 0;
  localparam int ADDR_W   = 16;
  localparam int BANK_LSB = 24;
  localparam int BANK_W   = 3;
  localparam int CS_LSB   = 32;
  localparam int CMD_LSB  = 40;
  localparam int CMD_W    = 3;
  localparam int ODT_LSB  = 48;
  localparam int CKE_LSB  = 56;

  // low bit of each swapped pair: A3/A4, A5/A6, A7/A8, BA0/BA1
  localparam logic [WORD_W-1:0] SWAP_LOW =
    (WORD_W'(1) << 3) | (WORD_W'(1) << 5) | (WORD_W'(1) << 7) |
    (WORD_W'(1) << BANK_LSB);

  typedef enum logic [CMD_W-1:0] {
    OP_MRS = 3'd0, OP_REF = 3'd1, OP_PRE = 3'd2, OP_ACT = 3'd3,
    OP_WR  = 3'd4, OP_RD  = 3'd5, OP_ZQ  = 3'd6, OP_NOP = 3'd7
  } cab_op_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0, CH_TEST = 2'd1, CH_REPLAY = 2'd2, CH_NORMAL = 2'd3
  } cab_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [RANKS-1:0]  cs_n;
    logic [CMD_W-1:0]  cmd;
    logic [RANKS-1:0]  odt;
    logic [RANKS-1:0]  cke;
  } cab_pins_t;

  function automatic cab_pins_t pins_idle();
    cab_pins_t p;
    p.addr = '0;
    p.bank = '0;
    p.cs_n = '1;
    p.cmd  = OP_NOP;
    p.odt  = '0;
    p.cke  = '1;
    return p;
  endfunction

  function automatic cab_pins_t word_to_pins(input logic [WORD_W-1:0] w);
    cab_pins_t p;
    p.addr = w[ADDR_LSB +: ADDR_W];
    p.bank = w[BANK_LSB +: BANK_W];
    p.cs_n = w[CS_LSB   +: RANKS];
    p.cmd  = w[CMD_LSB  +: CMD_W];
    p.odt  = w[ODT_LSB  +: RANKS];
    p.cke  = w[CKE_LSB  +: RANKS];
    return p;
  endfunction

  // swap each pair only where its two bits differ
  function automatic logic [WORD_W-1:0] swap_pairs(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] differ;
    differ = (w ^ (w >> 1)) & SWAP_LOW;
    return w ^ (differ | (differ << 1));
  endfunction

endpackage

// File: rtl/cab_store.sv
module cab_store
  import cab_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [RANKS-1:0]  mirror_en,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              ent_wr,
  input  logic [WORD_W-1:0] ent_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  load_idx;
  logic [PTR_W-1:0]  tgt_idx;
  logic              store_ok;
  logic              want_swap;
  logic [WORD_W-1:0] load_word;

  function automatic logic [PTR_W-1:0] after(input logic [PTR_W-1:0] i);
    return (i == PTR_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign store_ok  = ent_wr & ~busy;
  assign tgt_idx   = ptr_wr ? ptr_val : load_idx;
  assign want_swap = |(~ent_data[CS_LSB +: RANKS] & mirror_en);
  assign load_word = want_swap ? swap_pairs(ent_data) : ent_data;
  assign rd_word   = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_idx <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (store_ok) begin
        slots[tgt_idx] <= load_word;
        load_idx       <= after(tgt_idx);
      end else if (ptr_wr) begin
        load_idx <= ptr_val;
      end
    end
  end

endmodule

// File: rtl/cab_seq.sv
module cab_seq
  import cab_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PTR_W    = $clog2(DEPTH),
  parameter int GAP_W    = 3,
  parameter int DFLT_GAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ctl_wr,
  input  logic [GAP_W-1:0] ctl_gap,
  input  logic [PTR_W-1:0] ctl_start,
  input  logic [PTR_W-1:0] ctl_end,
  input  logic             ctl_go,
  input  logic             ctl_clr_err,
  input  logic             ent_wr,
  output logic             busy,
  output logic             launch,
  output logic             finish,
  output logic             issue,
  output logic             bad_start,
  output logic             drop,
  output logic [PTR_W-1:0] issue_idx,
  output logic [PTR_W-1:0] end_q,
  output logic [GAP_W-1:0] gap_eff,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             test_done,
  output logic             err
);

  logic [GAP_W-1:0] wait_cnt;
  logic             accept;
  logic             step;

  function automatic logic [GAP_W-1:0] real_gap(input logic [GAP_W-1:0] g);
    return (g == '0) ? GAP_W'(DFLT_GAP) : g;
  endfunction

  function automatic logic [PTR_W-1:0] after(input logic [PTR_W-1:0] i);
    return (i == PTR_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign accept    = ctl_wr & ctl_go & ~busy & (mode == CH_REPLAY);
  assign bad_start = accept & (ctl_end < ctl_start);
  assign launch    = accept & ~bad_start;
  assign finish    = busy & (cur_ptr == end_q);
  assign step      = busy & ~finish & (wait_cnt == '0);
  assign issue     = launch | step;
  assign issue_idx = launch ? ctl_start : after(cur_ptr);
  assign drop      = ent_wr & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_ptr  <= '0;
      end_q    <= '0;
      gap_eff  <= GAP_W'(DFLT_GAP);
      wait_cnt <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      cur_ptr  <= ctl_start;
      end_q    <= ctl_end;
      gap_eff  <= real_gap(ctl_gap);
      wait_cnt <= real_gap(ctl_gap);
    end else if (finish) begin
      busy <= 1'b0;
    end else if (step) begin
      cur_ptr  <= issue_idx;
      wait_cnt <= gap_eff;
    end else if (busy) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_done <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (accept)      test_done <= 1'b0;
      else if (finish) test_done <= 1'b1;
      if (bad_start | drop)          err <= 1'b1;
      else if (ctl_wr & ctl_clr_err) err <= 1'b0;
    end
  end

endmodule

// File: rtl/cab_pins.sv
module cab_pins
  import cab_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [WORD_W-1:0] word,
  output cab_pins_t         pins
);

  always_ff @(posedge clk) begin
    if (!rst_n)     pins <= pins_idle();
    else if (issue) pins <= word_to_pins(word);
    else            pins <= pins_idle();
  end

endmodule

// File: rtl/cab_replay.sv
module cab_replay
  import cab_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PTR_W    = $clog2(DEPTH),
  parameter int GAP_W    = 3,
  parameter int DFLT_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [RANKS-1:0]  mirror_en,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic              ent_wr,
  input  logic [WORD_W-1:0] ent_data,
  input  logic              ctl_wr,
  input  logic [GAP_W-1:0]  ctl_gap,
  input  logic [PTR_W-1:0]  ctl_start,
  input  logic [PTR_W-1:0]  ctl_end,
  input  logic              ctl_go,
  input  logic              ctl_clr_err,
  output logic [ADDR_W-1:0] ca_addr,
  output logic [BANK_W-1:0] ca_bank,
  output logic [RANKS-1:0]  ca_cs_n,
  output logic [CMD_W-1:0]  ca_cmd,
  output logic [RANKS-1:0]  ca_odt,
  output logic [RANKS-1:0]  ca_cke,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic              test_done,
  output logic              err
);

  logic              busy;
  logic              launch;
  logic              finish;
  logic              issue;
  logic              bad_start;
  logic              drop;
  logic [PTR_W-1:0]  issue_idx;
  logic [PTR_W-1:0]  end_q;
  logic [GAP_W-1:0]  gap_eff;
  logic [WORD_W-1:0] rd_word;
  cab_pins_t         pins;

  cab_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mirror_en(mirror_en),
    .ptr_wr(ptr_wr), .ptr_val(ptr_val), .ent_wr(ent_wr),
    .ent_data(ent_data), .rd_idx(issue_idx), .rd_word(rd_word)
  );

  cab_seq #(.DEPTH(DEPTH), .PTR_W(PTR_W), .GAP_W(GAP_W),
            .DFLT_GAP(DFLT_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_wr(ctl_wr),
    .ctl_gap(ctl_gap), .ctl_start(ctl_start), .ctl_end(ctl_end),
    .ctl_go(ctl_go), .ctl_clr_err(ctl_clr_err), .ent_wr(ent_wr),
    .busy(busy), .launch(launch), .finish(finish), .issue(issue),
    .bad_start(bad_start), .drop(drop), .issue_idx(issue_idx),
    .end_q(end_q), .gap_eff(gap_eff), .cur_ptr(cur_ptr),
    .test_done(test_done), .err(err)
  );

  cab_pins u_pins (
    .clk(clk), .rst_n(rst_n), .issue(issue), .word(rd_word), .pins(pins)
  );

  assign ca_addr = pins.addr;
  assign ca_bank = pins.bank;
  assign ca_cs_n = pins.cs_n;
  assign ca_cmd  = pins.cmd;
  assign ca_odt  = pins.odt;
  assign ca_cke  = pins.cke;

endmodule

// File: rtl/cab_replay_chk.sv
module cab_replay_chk #(
  parameter int PTR_W = 3,
  parameter int GAP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             ctl_wr,
  input logic             ctl_go,
  input logic             issue,
  input logic             launch,
  input logic             bad_start,
  input logic             drop,
  input logic             busy,
  input logic [GAP_W-1:0] gap_eff,
  input logic [PTR_W-1:0] end_q,
  input logic [PTR_W-1:0] cur_ptr,
  input logic             test_done,
  input logic             err,
  input logic [2:0]       ca_cmd,
  input logic [3:0]       ca_cs_n
);

  // cycles elapsed since the most recent issue
  logic [7:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)              since <= '0;
    else if (issue)          since <= '0;
    else if (since != 8'hFF) since <= since + 1'b1;
  end

  a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !launch) |-> (since == 8'(gap_eff)));

  a_r6_done_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_done) |-> (cur_ptr == end_q));

  a_r5_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_done) |-> (ca_cmd == 3'd7 && ca_cs_n == 4'hF));

  a_r8_drop_err: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err);

  a_r7_bad_range: assert property (@(posedge clk) disable iff (!rst_n)
    bad_start |=> (err && !busy && ca_cs_n == 4'hF));

  a_r3_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_go && mode != 2'd2 && !busy) |=> (!busy && ca_cs_n == 4'hF));

endmodule

bind cab_replay cab_replay_chk #(.PTR_W(PTR_W), .GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
  .issue(issue), .launch(launch), .bad_start(bad_start), .drop(drop),
  .busy(busy), .gap_eff(gap_eff), .end_q(end_q), .cur_ptr(cur_ptr),
  .test_done(test_done), .err(err), .ca_cmd(ca_cmd), .ca_cs_n(ca_cs_n)
);

// File: tb/tb_cab_replay.sv
module tb_cab_replay;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  mirror_en = 4'h0;
  logic        ptr_wr = 1'b0;
  logic [2:0]  ptr_val = '0;
  logic        ent_wr = 1'b0;
  logic [63:0] ent_data = '0;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_gap = '0, ctl_start = '0, ctl_end = '0;
  logic        ctl_go = 1'b0, ctl_clr_err = 1'b0;
  logic [15:0] ca_addr;
  logic [2:0]  ca_bank, ca_cmd, cur_ptr;
  logic [3:0]  ca_cs_n, ca_odt, ca_cke;
  logic        test_done, err;

  cab_replay dut (.*);

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int idle_run = 0;

  logic [33:0] exp_bus [$];
  int          exp_gap [$];
  string       exp_tag [$];
  logic [63:0] ref_mem [8];
  logic [2:0]  ref_wptr = '0;

  wire [33:0] cur_bus = {ca_addr, ca_bank, ca_cs_n, ca_cmd, ca_odt, ca_cke};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(input logic [15:0] a, input logic [2:0] b,
                                     input logic [3:0] cs, input logic [2:0] c,
                                     input logic [3:0] o, input logic [3:0] k);
    logic [63:0] w = '0;
    w[15:0] = a; w[26:24] = b; w[35:32] = cs;
    w[42:40] = c; w[51:48] = o; w[59:56] = k;
    return w;
  endfunction

  function automatic logic [33:0] pins_of(input logic [63:0] w);
    return {w[15:0], w[26:24], w[35:32], w[42:40], w[51:48], w[59:56]};
  endfunction

  function automatic logic [63:0] flip(input logic [63:0] w);
    logic [63:0] r = w;
    r[3] = w[4];   r[4] = w[3];
    r[5] = w[6];   r[6] = w[5];
    r[7] = w[8];   r[8] = w[7];
    r[24] = w[25]; r[25] = w[24];
    return r;
  endfunction

  task automatic pulse_ptr(input logic [2:0] p);
    @(posedge clk); #1 ptr_wr = 1'b1; ptr_val = p;
    @(posedge clk); #1 ptr_wr = 1'b0;
    ref_wptr = p;
  endtask

  task automatic pulse_ent(input logic [63:0] d, input bit dropped);
    @(posedge clk); #1 ent_wr = 1'b1; ent_data = d;
    @(posedge clk); #1 ent_wr = 1'b0;
    if (!dropped) begin
      ref_mem[ref_wptr] = ((~d[35:32] & mirror_en) != 0) ? flip(d) : d;
      ref_wptr = ref_wptr + 3'd1;
    end
  endtask

  task automatic pulse_ctl(input logic [2:0] g, input logic [2:0] s,
                           input logic [2:0] e, input bit go, input bit clr);
    @(posedge clk); #1
    ctl_wr = 1'b1; ctl_gap = g; ctl_start = s; ctl_end = e;
    ctl_go = go; ctl_clr_err = clr;
    @(posedge clk); #1 ctl_wr = 1'b0; ctl_go = 1'b0; ctl_clr_err = 1'b0;
  endtask

  task automatic push(input logic [63:0] w, input int g, input string tag);
    exp_bus.push_back(pins_of(w));
    exp_gap.push_back(g);
    exp_tag.push_back(tag);
  endtask

  task automatic queue_range(input logic [2:0] g, input int s, input int e,
                             input string tag);
    int eff = (g == 0) ? 3 : int'(g);
    for (int i = s; i <= e; i++) push(ref_mem[i], (i == s) ? -1 : eff, tag);
  endtask

  task automatic wait_done(input logic [2:0] e);
    int n = 0;
    while (!test_done && n < 400) begin @(negedge clk); n++; end
    check(test_done == 1'b1, "R6", "done after replay", test_done, 1);
    check(cur_ptr == e, "R6", "current slot at end", cur_ptr, e);
    check(exp_bus.size() == 0, "R3", "all slots issued", exp_bus.size(), 0);
    check(cur_bus == {16'h0, 3'd0, 4'hF, 3'd7, 4'h0, 4'hF}, "R5",
          "idle pins after replay", cur_bus, {16'h0, 3'd0, 4'hF, 3'd7, 4'h0, 4'hF});
  endtask

  task automatic run(input logic [2:0] g, input int s, input int e, input string tag);
    queue_range(g, s, e, tag);
    pulse_ctl(g, 3'(s), 3'(e), 1'b1, 1'b0);
    wait_done(3'(e));
  endtask

  // monitor: pops one expected word per active bus cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!(ca_cmd == 3'd7 && ca_cs_n == 4'hF)) begin
        if (exp_bus.size() == 0) begin
          check(1'b0, "R3", "unexpected command on pins", cur_bus, 0);
        end else begin
          logic [33:0] b;
          int g;
          string t;
          b = exp_bus.pop_front();
          g = exp_gap.pop_front();
          t = exp_tag.pop_front();
          check(cur_bus == b, t, "issued pins", cur_bus, b);
          if (g >= 0) check(idle_run == g, "R4", "idle gap", idle_run, g);
        end
        idle_run = 0;
      end else begin
        idle_run++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 / R5: reset state
    check(test_done == 0 && err == 0, "R11", "flags after reset", {test_done, err}, 0);
    check(cur_ptr == 0, "R11", "slot after reset", cur_ptr, 0);
    check(cur_bus == {16'h0, 3'd0, 4'hF, 3'd7, 4'h0, 4'hF}, "R5", "idle pins after reset",
          cur_bus, {16'h0, 3'd0, 4'hF, 3'd7, 4'h0, 4'hF});

    // R2: load eight words with automatic index advance
    for (int i = 0; i < 8; i++)
      pulse_ent(mk(16'h1000 + 16'(i) * 16'h0111, 3'(7 - i), ~(4'b1 << (i % 4)),
                   3'(i), 4'(i), 4'hF - 4'(i)), 1'b0);
    mode = 2'd2;
    run(3'd0, 0, 7, "R1");     // default gap of 3, every command code
    run(3'd1, 2, 4, "R1");
    run(3'd7, 5, 5, "R1");
    run(3'd2, 6, 7, "R1");

    // R2: wrap of the load index from slot 7 to slot 0
    pulse_ptr(3'd7);
    pulse_ent(mk(16'hBEEF, 3'd5, 4'b0111, 3'd3, 4'h8, 4'h8), 1'b0);
    pulse_ent(mk(16'hCAFE, 3'd6, 4'b1011, 3'd4, 4'h4, 4'h4), 1'b0);
    run(3'd1, 7, 7, "R2");
    run(3'd1, 0, 0, "R2");

    // R3: go in non-replay modes is ignored
    mode = 2'd1;
    pulse_ctl(3'd1, 3'd0, 3'd3, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(test_done == 1'b1, "R3", "done kept in test mode", test_done, 1);
    mode = 2'd3;
    pulse_ctl(3'd1, 3'd1, 3'd2, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(cur_ptr == 3'd0, "R3", "slot kept in normal mode", cur_ptr, 0);
    mode = 2'd2;

    // R7: reversed range
    pulse_ctl(3'd1, 3'd5, 3'd2, 1'b1, 1'b0);
    @(negedge clk);
    check(err == 1'b1, "R7", "error on reversed range", err, 1);
    repeat (15) @(negedge clk);
    check(cur_ptr == 3'd0, "R7", "no slot issued", cur_ptr, 0);

    // R9: clear errors
    pulse_ctl(3'd1, 3'd0, 3'd0, 1'b0, 1'b1);
    @(negedge clk);
    check(err == 1'b0, "R9", "error cleared", err, 0);

    // R8: word write during a replay
    queue_range(3'd7, 0, 7, "R1");
    pulse_ctl(3'd7, 3'd0, 3'd7, 1'b1, 1'b0);
    repeat (4) @(posedge clk);
    pulse_ent(mk(16'h5555, 3'd1, 4'b1110, 3'd0, 4'h0, 4'h0), 1'b1);
    @(negedge clk);
    check(err == 1'b1, "R8", "error on write during replay", err, 1);
    wait_done(3'd7);
    run(3'd1, int'(ref_wptr), int'(ref_wptr), "R8");
    pulse_ctl(3'd1, 3'd0, 3'd0, 1'b0, 1'b1);

    // R10: mirroring applied at load time for rank 1 only
    mirror_en = 4'b0010;
    pulse_ptr(3'd0);
    pulse_ent(mk(16'h0128, 3'd1, 4'b1101, 3'd0, 4'h2, 4'hF), 1'b0);
    pulse_ent(mk(16'h0128, 3'd1, 4'b1110, 3'd0, 4'h1, 4'hF), 1'b0);
    mirror_en = 4'b0000;
    push(mk(16'h00D0, 3'd2, 4'b1101, 3'd0, 4'h2, 4'hF), -1, "R10");
    push(mk(16'h0128, 3'd1, 4'b1110, 3'd0, 4'h1, 4'hF), 2, "R10");
    pulse_ctl(3'd2, 3'd0, 3'd1, 1'b1, 1'b0);
    wait_done(3'd1);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule